// File: doc/BRIEF.md
# Mode-Tagged Instruction Prefetch Queue

This block sits between instruction fetch and execution and lets decode run ahead of execute. Each fetched instruction is decoded into an opcode class as it enters a small first-in, first-out queue. At that moment the entry is stamped with the protection-enable (PE) bit held by the block. The execution side takes entries from the head with a ready/valid handshake. With each entry it receives the opcode, its class, the mode tag recorded at decode, and a flag for opcodes that the tagged mode does not allow.

Software changes PE through a write port. Entries already waiting in the queue keep the mode they were decoded under. A taken jump flushes the queue so that later fetches are decoded afresh under the current PE value. A disallowed opcode raises a trap as soon as it reaches the head. The handler table chosen for that trap follows the live PE value, not the stale decode tag.

Top module: `mtq_prefetch`

## Requirements
- R1: The queue holds 4 entries. `fetch_ready` is high exactly when the queue is not full, and a fetch is accepted only when `fetch_valid` and `fetch_ready` are both high. `q_full` and `q_empty` report 4 and 0 stored entries.
- R2: Entries leave the queue in the order they were accepted. A pop happens when `exec_valid` and `exec_ready` are both high, and the head is presented combinationally on the exec outputs.
- R3: The class of an entry is opcode bits [7:5]. The tag of an entry is the PE value held by the block in the cycle the fetch is accepted, where 0 means real mode and 1 means protected mode.
- R4: Changing PE never alters the tag of an entry that is already queued. Such an entry still presents its original tag when it reaches the head.
- R5: A PE write in cycle N appears on `pe_mode` from cycle N+1, and it is applied to fetches accepted from cycle N+1 onward. A fetch accepted in cycle N itself gets the old value.
- R6: `exec_illegal` is high exactly when the head class is 3'b111 (protected-only) and the head tag is 0.
- R7: `exec_trap` is high exactly when `exec_valid` and `exec_illegal` are both high. `exec_trap_tbl` equals the live `pe_mode`, with 0 selecting the real-mode table and 1 the protected-mode table.
- R8: `jump_flush` empties the queue by the next cycle. A fetch offered in the same cycle is discarded, and a pop in the same cycle has no further effect.
- R9: Asserting `exec_ready` while the queue is empty is ignored, and the queue stays empty.
- R10: After reset the queue is empty, `fetch_ready` is 1 and `pe_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetched instruction available |
| fetch_opcode | input | 8 | Fetched opcode |
| fetch_ready | output | 1 | Queue can accept a fetch |
| pe_wr_en | input | 1 | Write strobe for the PE bit |
| pe_wr_data | input | 1 | New PE value |
| jump_flush | input | 1 | Taken jump, discards every queued entry |
| exec_ready | input | 1 | Execution side takes the head entry |
| exec_valid | output | 1 | Head entry present |
| exec_opcode | output | 8 | Head opcode |
| exec_class | output | 3 | Head opcode class |
| exec_tag_pe | output | 1 | Mode recorded when the head was decoded |
| exec_illegal | output | 1 | Head opcode not allowed in its tagged mode |
| exec_trap | output | 1 | Trap request for the head entry |
| exec_trap_tbl | output | 1 | Trap table select from the live mode |
| pe_mode | output | 1 | Current PE value |
| q_full | output | 1 | Queue holds 4 entries |
| q_empty | output | 1 | Queue holds no entries |

## Verification
Some properties are checked by the assertions on every cycle:
- full/ready exclusion;
- flush-to-empty on the next cycle;
- the one-cycle latency of a PE write;
- the conditions under which a trap may fire and which table it uses;
- a stalled head staying stable;
- an empty queue staying empty under pops alone.

Other properties need a sequence of cycles, so only the bench scenarios, compared each cycle against a behavioural queue model, can show them:
- first-in, first-out ordering across fills and drains;
- stale real-mode tags surviving a switch to protected mode;
- the loss of a fetch offered together with a flush;
- tags picking up a PE write exactly one cycle later.

// File: rtl/mtq_pkg.sv
package mtq_pkg;
  localparam int OPC_W = 8;
  localparam int CLS_W = 3;
  localparam logic [CLS_W-1:0] CLS_PROT_ONLY = 3'b111;

  typedef struct packed {
    logic [OPC_W-1:0] opcode;
    logic [CLS_W-1:0] cls;
    logic             tag_pe;
  } mtq_entry_t;

  localparam int ENTRY_W = $bits(mtq_entry_t);
endpackage

// File: rtl/mtq_mode_reg.sv
module mtq_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_data,
  output logic pe_q
);
  logic pe_d;

  always_comb begin
    pe_d = pe_q;
    if (wr_en) pe_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pe_q <= 1'b0;
    else        pe_q <= pe_d;
  end
endmodule

// File: rtl/mtq_decode.sv
module mtq_decode
  import mtq_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic             pe,
  output mtq_entry_t       entry
);
  always_comb begin
    entry.opcode = opcode;
    entry.cls    = opcode[OPC_W-1 -: CLS_W];
    entry.tag_pe = pe;
  end
endmodule

// File: rtl/mtq_fifo.sv
module mtq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wr_data,
  input  logic         pop,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     mem_q [DEPTH];
  logic             do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rd_data = mem_q[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + PTR_W'(1);
      if (do_pop)  rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = do_push && (wr_ptr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (slot_en) mem_q[i] <= wr_data;
    end
  end
endmodule

// File: rtl/mtq_exec_sel.sv
module mtq_exec_sel
  import mtq_pkg::*;
(
  input  logic             head_valid,
  input  logic [CLS_W-1:0] head_cls,
  input  logic             head_tag,
  input  logic             live_pe,
  output logic             illegal,
  output logic             trap,
  output logic             trap_tbl
);
  always_comb begin
    illegal  = (head_cls == CLS_PROT_ONLY) && !head_tag;
    trap     = head_valid && illegal;
    trap_tbl = live_pe;
  end
endmodule

// File: rtl/mtq_prefetch.sv
module mtq_prefetch
  import mtq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [OPC_W-1:0] fetch_opcode,
  output logic             fetch_ready,
  input  logic             pe_wr_en,
  input  logic             pe_wr_data,
  input  logic             jump_flush,
  input  logic             exec_ready,
  output logic             exec_valid,
  output logic [OPC_W-1:0] exec_opcode,
  output logic [CLS_W-1:0] exec_class,
  output logic             exec_tag_pe,
  output logic             exec_illegal,
  output logic             exec_trap,
  output logic             exec_trap_tbl,
  output logic             pe_mode,
  output logic             q_full,
  output logic             q_empty
);
  mtq_entry_t dec_entry, head_entry;
  logic [ENTRY_W-1:0] head_bits;

  mtq_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(pe_wr_en), .wr_data(pe_wr_data), .pe_q(pe_mode)
  );

  mtq_decode u_dec (
    .opcode(fetch_opcode), .pe(pe_mode), .entry(dec_entry)
  );

  mtq_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(jump_flush),
    .push(fetch_valid), .wr_data(dec_entry),
    .pop(exec_ready), .rd_data(head_bits),
    .full(q_full), .empty(q_empty)
  );

  assign head_entry  = mtq_entry_t'(head_bits);
  assign fetch_ready = !q_full;
  assign exec_valid  = !q_empty;
  assign exec_opcode = head_entry.opcode;
  assign exec_class  = head_entry.cls;
  assign exec_tag_pe = head_entry.tag_pe;

  mtq_exec_sel u_sel (
    .head_valid(exec_valid), .head_cls(head_entry.cls), .head_tag(head_entry.tag_pe),
    .live_pe(pe_mode), .illegal(exec_illegal), .trap(exec_trap), .trap_tbl(exec_trap_tbl)
  );
endmodule

// File: rtl/mtq_prefetch_chk.sv
module mtq_prefetch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fetch_valid,
  input logic       fetch_ready,
  input logic       pe_wr_en,
  input logic       pe_wr_data,
  input logic       jump_flush,
  input logic       exec_ready,
  input logic       exec_valid,
  input logic [7:0] exec_opcode,
  input logic [2:0] exec_class,
  input logic       exec_tag_pe,
  input logic       exec_trap,
  input logic       exec_trap_tbl,
  input logic       pe_mode,
  input logic       q_full,
  input logic       q_empty
);
  AST_FULL_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> (!fetch_ready && exec_valid)); // R1
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && !exec_ready && !jump_flush) |=> (exec_valid && $stable(exec_opcode) && $stable(exec_tag_pe))); // R2
  AST_PE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pe_wr_en |=> (pe_mode == $past(pe_wr_data))); // R5
  AST_PE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_wr_en |=> $stable(pe_mode)); // R5
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_trap |-> (exec_valid && !exec_tag_pe && exec_class == 3'b111)); // R6
  AST_TRAP_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_trap |-> (exec_trap_tbl == pe_mode)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    jump_flush |=> q_empty); // R8
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && !fetch_valid) |=> q_empty); // R9
endmodule

bind mtq_prefetch mtq_prefetch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
  .pe_wr_en(pe_wr_en), .pe_wr_data(pe_wr_data), .jump_flush(jump_flush),
  .exec_ready(exec_ready), .exec_valid(exec_valid), .exec_opcode(exec_opcode),
  .exec_class(exec_class), .exec_tag_pe(exec_tag_pe), .exec_trap(exec_trap),
  .exec_trap_tbl(exec_trap_tbl), .pe_mode(pe_mode), .q_full(q_full), .q_empty(q_empty)
);

// File: tb/mtq_prefetch_test.sv
`timescale 1ns/1ps
module mtq_prefetch_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fv = 1'b0, pwe = 1'b0, pwd = 1'b0, fl = 1'b0, er = 1'b0;
  logic [7:0] fop = 8'h00;
  logic fetch_ready, exec_valid, exec_tag_pe, exec_illegal, exec_trap, exec_trap_tbl;
  logic pe_mode, q_full, q_empty;
  logic [7:0] exec_opcode;
  logic [2:0] exec_class;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int m_op[$];
  bit m_tag[$];
  bit m_pe = 0;

  always #4 clk = ~clk;

  mtq_prefetch uut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fv), .fetch_opcode(fop), .fetch_ready(fetch_ready),
    .pe_wr_en(pwe), .pe_wr_data(pwd), .jump_flush(fl), .exec_ready(er),
    .exec_valid(exec_valid), .exec_opcode(exec_opcode), .exec_class(exec_class),
    .exec_tag_pe(exec_tag_pe), .exec_illegal(exec_illegal), .exec_trap(exec_trap),
    .exec_trap_tbl(exec_trap_tbl), .pe_mode(pe_mode), .q_full(q_full), .q_empty(q_empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    int sz = m_op.size();
    chk(q_empty == (sz == 0), "R1 q_empty", q_empty, sz == 0);
    chk(q_full == (sz == 4), "R1 q_full", q_full, sz == 4);
    chk(fetch_ready == (sz < 4), "R1 fetch_ready", fetch_ready, sz < 4);
    chk(exec_valid == (sz > 0), "R2 exec_valid", exec_valid, sz > 0);
    chk(pe_mode == m_pe, "R5 pe_mode", pe_mode, m_pe);
    chk(exec_trap_tbl == m_pe, "R7 trap table", exec_trap_tbl, m_pe);
    if (sz > 0) begin
      bit ill = (m_op[0][7:5] == 3'b111) && !m_tag[0];
      chk(exec_opcode == m_op[0][7:0], "R2 head opcode", exec_opcode, m_op[0]);
      chk(exec_class == m_op[0][7:5], "R3 class", exec_class, m_op[0][7:5]);
      chk(exec_tag_pe == m_tag[0], "R4 tag", exec_tag_pe, m_tag[0]);
      chk(exec_illegal == ill, "R6 illegal", exec_illegal, ill);
      chk(exec_trap == ill, "R7 trap", exec_trap, ill);
    end else begin
      chk(exec_trap == 1'b0, "R7 trap when empty", exec_trap, 0);
    end
  endtask

  // one clock: drive at negedge, model update at posedge, compare at next negedge
  task automatic cyc(input bit v, input logic [7:0] op, input bit we, input bit wd,
                     input bit f, input bit rd);
    bit acc_push, acc_pop;
    fv = v; fop = op; pwe = we; pwd = wd; fl = f; er = rd;
    @(posedge clk);
    acc_push = v && (m_op.size() < 4);
    acc_pop  = rd && (m_op.size() > 0);
    if (f) begin
      m_op.delete(); m_tag.delete();
    end else begin
      if (acc_pop) begin void'(m_op.pop_front()); void'(m_tag.pop_front()); end
      if (acc_push) begin m_op.push_back(int'(op)); m_tag.push_back(m_pe); end
    end
    if (we) m_pe = wd;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(q_empty == 1'b1, "R10 empty after reset", q_empty, 1);
    chk(fetch_ready == 1'b1, "R10 ready after reset", fetch_ready, 1);
    chk(pe_mode == 1'b0, "R10 pe after reset", pe_mode, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R9: pop on empty ignored
    cyc(0, 8'h00, 0, 0, 0, 1);
    chk(q_empty == 1'b1, "R9 pop on empty", q_empty, 1);

    // R1/R2: fill, push while full, drain in order
    for (int i = 0; i < 5; i++) cyc(1, 8'(8'h10 + i), 0, 0, 0, 0);
    chk(q_full == 1'b1, "R1 full after five offers", q_full, 1);
    for (int i = 0; i < 4; i++) begin
      chk(exec_opcode == 8'(8'h10 + i), "R2 fifo order", exec_opcode, 8'h10 + i);
      cyc(0, 8'h00, 0, 0, 0, 1);
    end

    // R4/R6/R7: real-mode entries queued, PE set, then drained
    cyc(1, 8'hE3, 0, 0, 0, 0);
    cyc(1, 8'h41, 1, 1, 0, 0);          // R5: pushed with old PE 0
    cyc(1, 8'hE5, 0, 0, 0, 0);          // tagged protected
    chk(exec_tag_pe == 1'b0, "R4 stale real tag kept", exec_tag_pe, 0);
    chk(exec_trap == 1'b1, "R7 trap for real-tagged prot-only", exec_trap, 1);
    chk(exec_trap_tbl == 1'b1, "R7 live protected table", exec_trap_tbl, 1);
    cyc(0, 8'h00, 0, 0, 0, 1);
    chk(exec_tag_pe == 1'b0, "R5 write-cycle push keeps old PE", exec_tag_pe, 0);
    cyc(0, 8'h00, 0, 0, 0, 1);
    chk(exec_tag_pe == 1'b1, "R3 new tag after write", exec_tag_pe, 1);
    chk(exec_illegal == 1'b0, "R6 prot-only legal when tagged protected", exec_illegal, 0);
    cyc(0, 8'h00, 0, 0, 0, 1);

    // R8: flush with simultaneous push and pop
    cyc(1, 8'h21, 0, 0, 0, 0);
    cyc(1, 8'h22, 0, 0, 0, 0);
    cyc(1, 8'h23, 0, 0, 1, 1);
    chk(q_empty == 1'b1, "R8 flush drops push", q_empty, 1);
    cyc(1, 8'hE0, 1, 0, 0, 0);
    chk(exec_tag_pe == 1'b1, "R8 refetch under current mode", exec_tag_pe, 1);
    cyc(0, 8'h00, 0, 0, 1, 0);

    // mixed traffic
    for (int i = 0; i < 3000; i++)
      cyc($urandom_range(0, 3) != 0, 8'($urandom_range(0, 255)), $urandom_range(0, 9) == 0,
          1'($urandom_range(0, 1)), $urandom_range(0, 29) == 0, $urandom_range(0, 2) != 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule